// File: doc/BRIEF.md
# Microcoded Control Sequencer with Interrupt Branch

This block is the control unit of a 32-bit multicycle processor. A 6-bit microstate register steps through a combinational control store. Each microstate emits a 28-bit control word that drives the bus enables, register loads, write strobes, ALU function and register select of the surrounding datapath. The next microstate comes from one of four sources: the next-state field of the store, an opcode dispatch table, a branch table keyed by the zero flag, or a branch table keyed by the interrupt condition.

Interrupt entry needs no separate macrostate. The first fetch microstate also tests whether interrupts are enabled and a request is pending. If so, the sequencer leaves the fetch path. It saves the PC into register 12, clears the interrupt-enable flag, acknowledges the device, and reloads the PC from the vector table entry that the device index selects. The enable flag is held inside the block. The enable, disable and return-from-interrupt instructions change it. The block also turns the 2-bit register-select field into a register index. That index is either one of the three instruction fields or the reserved register 12.

Top module: `useq_ctrl`

## Requirements
- R1: While rst is high on a rising edge, the next cycle shows state_o = 0 and ie_o = 0.
- R2: The ctrl_o layout is as follows:
  - next state: bits 5:0
  - bus drivers: register file bit 6, memory 7, ALU 8, PC 9, sign-extended offset 10, enable flag 26
  - loads: PC 11, IR 12, MAR 13, A 14, B 15, zero flag 16
  - writes: register write 17, memory write 18
  - register select: bits 20:19
  - ALU function: bits 22:21 (00 add, 01 nand, 10 A minus B, 11 A plus 1)
  - opcode test: bit 23; zero test: bit 24; enable-flag load: bit 25; interrupt acknowledge: bit 27
  - In state 0 the full word is 0x0006201.
- R3: With no interrupt taken, fetch runs through three states:
  - State 0 drives PC and loads MAR and A.
  - State 1 drives memory and loads IR.
  - State 2 drives the ALU in A-plus-1 mode, loads PC and tests the opcode in ir_i[31:28].
- R4: reg_idx_o follows register select: 00 gives ir_i[27:24], 01 gives ir_i[23:20], 10 gives ir_i[3:0], and 11 gives 12.
- R5: If ie_o and irq_i are both high in state 0, the sequencer goes through states 33, 34 and 35, then returns to 0:
  - State 33 drives PC, writes register 12 and clears the enable flag.
  - State 34 raises acknowledge, loads MAR and drives nothing itself.
  - State 35 drives memory and loads PC.
- R6: In state 0, irq_i is ignored while ie_o is low: the next state is 1.
- R7: Opcode 1010 goes to state 30 and sets ie_o. Opcode 1011 goes to state 31 and clears it. Either way the new value shows in the following state 0.
- R8: Opcode 1100 goes to state 32. State 32 drives register 12, loads PC and sets ie_o.
- R9: Opcode 0101 compares through states 21, 22 and 23, using RX then RY and the A-minus-B ALU code with a zero-flag load. State 24 drives PC into A and tests zero_i. If zero_i is high it goes to 25 (offset into B), then to 26 (add, load PC). Otherwise it goes back to 0.
- R10: Opcodes 1000, 1001, 1101, 1110 and 1111 go from state 2 straight back to state 0.
- R11: Opcode 0111 enters state 29 and stays there until reset.
- R12: At most one of the six bus-driver bits is high in any state. No driver bit is high while acknowledge is high.
- R13: Opcode 0000 runs states 4, 5 and 6: RY into A, RZ into B, then ALU add written to RX. Opcode 0001 does the same in states 7, 8 and 9 with the nand code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ir_i | input | 32 | Current instruction register contents |
| zero_i | input | 1 | Registered zero flag from the datapath |
| irq_i | input | 1 | Pending interrupt request from the device |
| ctrl_o | output | 28 | Control word of the current microstate |
| reg_idx_o | output | 4 | Decoded register-file index |
| ie_o | output | 1 | Interrupt-enable flag |
| state_o | output | 6 | Current microstate |

## Verification
ctrl_o and reg_idx_o depend only on the current state and ir_i, so they are due in the same cycle as the state that produces them. A new state appears one rising edge after the state that selected it. A change to the enable flag appears one edge after the state that loads it, which is the next state in the sequence. The driver places each instruction's inputs just after a rising edge while state 0 is showing, and queues one expected item per cycle with the enable value for that cycle. The monitor pops and compares one item on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ST_W    = 6;
    localparam int IR_W    = 32;
    localparam int OP_W    = 4;
    localparam int RIDX_W  = 4;
    localparam int CW_W    = 28;
    localparam int K0_IDX  = 12;
    localparam int OP_LSB  = IR_W - OP_W;
    localparam int RX_LSB  = OP_LSB - RIDX_W;
    localparam int RY_LSB  = RX_LSB - RIDX_W;
    localparam int RZ_LSB  = 0;

    typedef logic [ST_W-1:0] st_t;
    typedef logic [OP_W-1:0] op_t;

    typedef enum logic [1:0] {SEL_RX, SEL_RY, SEL_RZ, SEL_K0} rsel_e;
    typedef enum logic [1:0] {ALU_ADD, ALU_NAND, ALU_SUB, ALU_INC} alu_e;

    // field order follows the bit positions decoded by the datapath
    typedef struct packed {
        logic  int_ack;
        logic  dr_ie;
        logic  ld_ie;
        logic  chk_z;
        logic  op_test;
        alu_e  alu;
        rsel_e rsel;
        logic  wr_mem;
        logic  wr_reg;
        logic  ld_z;
        logic  ld_b;
        logic  ld_a;
        logic  ld_mar;
        logic  ld_ir;
        logic  ld_pc;
        logic  dr_off;
        logic  dr_pc;
        logic  dr_alu;
        logic  dr_mem;
        logic  dr_reg;
        st_t   nxt;
    } ctrl_t;

    localparam st_t S_F0     = st_t'(0);
    localparam st_t S_F1     = st_t'(1);
    localparam st_t S_F2     = st_t'(2);
    localparam st_t S_ADD_A  = st_t'(4);
    localparam st_t S_ADD_B  = st_t'(5);
    localparam st_t S_ADD_W  = st_t'(6);
    localparam st_t S_NAND_A = st_t'(7);
    localparam st_t S_NAND_B = st_t'(8);
    localparam st_t S_NAND_W = st_t'(9);
    localparam st_t S_ADDI_A = st_t'(10);
    localparam st_t S_ADDI_B = st_t'(11);
    localparam st_t S_ADDI_W = st_t'(12);
    localparam st_t S_LW_A   = st_t'(13);
    localparam st_t S_LW_B   = st_t'(14);
    localparam st_t S_LW_M   = st_t'(15);
    localparam st_t S_LW_W   = st_t'(16);
    localparam st_t S_SW_A   = st_t'(17);
    localparam st_t S_SW_B   = st_t'(18);
    localparam st_t S_SW_M   = st_t'(19);
    localparam st_t S_SW_W   = st_t'(20);
    localparam st_t S_BQ_A   = st_t'(21);
    localparam st_t S_BQ_B   = st_t'(22);
    localparam st_t S_BQ_C   = st_t'(23);
    localparam st_t S_BQ_T   = st_t'(24);
    localparam st_t S_BQ_O   = st_t'(25);
    localparam st_t S_BQ_J   = st_t'(26);
    localparam st_t S_JL_L   = st_t'(27);
    localparam st_t S_JL_J   = st_t'(28);
    localparam st_t S_HALT   = st_t'(29);
    localparam st_t S_EI     = st_t'(30);
    localparam st_t S_DI     = st_t'(31);
    localparam st_t S_RETI   = st_t'(32);
    localparam st_t S_IN_SV  = st_t'(33);
    localparam st_t S_IN_AK  = st_t'(34);
    localparam st_t S_IN_VC  = st_t'(35);

    // microstate whose successor comes from the interrupt table
    localparam st_t INT_CHECK_ST = S_F0;

    function automatic st_t dispatch_tab(input op_t op);
        case (op)
            4'h0:    return S_ADD_A;
            4'h1:    return S_NAND_A;
            4'h2:    return S_ADDI_A;
            4'h3:    return S_LW_A;
            4'h4:    return S_SW_A;
            4'h5:    return S_BQ_A;
            4'h6:    return S_JL_L;
            4'h7:    return S_HALT;
            4'hA:    return S_EI;
            4'hB:    return S_DI;
            4'hC:    return S_RETI;
            default: return S_F0;
        endcase
    endfunction

    function automatic st_t zero_tab(input logic [1:0] addr);
        case (addr)
            2'd1:    return S_BQ_O;
            default: return S_F0;
        endcase
    endfunction

    function automatic st_t int_tab(input logic [1:0] addr);
        case (addr)
            2'd0:    return S_F1;
            2'd1:    return S_IN_SV;
            default: return S_F0;
        endcase
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  st_t   st,
    output ctrl_t cw,
    output logic  ie_val
);

    always_comb begin
        cw     = '0;
        ie_val = 1'b0;
        cw.nxt = S_F0;
        case (st)
            S_F0: begin
                cw.dr_pc = 1'b1; cw.ld_mar = 1'b1; cw.ld_a = 1'b1; cw.nxt = S_F1;
            end
            S_F1: begin
                cw.dr_mem = 1'b1; cw.ld_ir = 1'b1; cw.nxt = S_F2;
            end
            S_F2: begin
                cw.dr_alu = 1'b1; cw.alu = ALU_INC; cw.ld_pc = 1'b1; cw.op_test = 1'b1;
            end
            S_ADD_A, S_NAND_A, S_ADDI_A, S_LW_A, S_SW_A: begin
                cw.dr_reg = 1'b1; cw.rsel = SEL_RY; cw.ld_a = 1'b1; cw.nxt = st + st_t'(1);
            end
            S_ADD_B, S_NAND_B: begin
                cw.dr_reg = 1'b1; cw.rsel = SEL_RZ; cw.ld_b = 1'b1; cw.nxt = st + st_t'(1);
            end
            S_ADDI_B, S_LW_B, S_SW_B: begin
                cw.dr_off = 1'b1; cw.ld_b = 1'b1; cw.nxt = st + st_t'(1);
            end
            S_ADD_W, S_ADDI_W: begin
                cw.dr_alu = 1'b1; cw.alu = ALU_ADD; cw.wr_reg = 1'b1; cw.rsel = SEL_RX;
            end
            S_NAND_W: begin
                cw.dr_alu = 1'b1; cw.alu = ALU_NAND; cw.wr_reg = 1'b1; cw.rsel = SEL_RX;
            end
            S_LW_M, S_SW_M: begin
                cw.dr_alu = 1'b1; cw.alu = ALU_ADD; cw.ld_mar = 1'b1; cw.nxt = st + st_t'(1);
            end
            S_LW_W: begin
                cw.dr_mem = 1'b1; cw.wr_reg = 1'b1; cw.rsel = SEL_RX;
            end
            S_SW_W: begin
                cw.dr_reg = 1'b1; cw.rsel = SEL_RX; cw.wr_mem = 1'b1;
            end
            S_BQ_A: begin
                cw.dr_reg = 1'b1; cw.rsel = SEL_RX; cw.ld_a = 1'b1; cw.nxt = S_BQ_B;
            end
            S_BQ_B: begin
                cw.dr_reg = 1'b1; cw.rsel = SEL_RY; cw.ld_b = 1'b1; cw.nxt = S_BQ_C;
            end
            S_BQ_C: begin
                cw.dr_alu = 1'b1; cw.alu = ALU_SUB; cw.ld_z = 1'b1; cw.nxt = S_BQ_T;
            end
            S_BQ_T: begin
                cw.dr_pc = 1'b1; cw.ld_a = 1'b1; cw.chk_z = 1'b1;
            end
            S_BQ_O: begin
                cw.dr_off = 1'b1; cw.ld_b = 1'b1; cw.nxt = S_BQ_J;
            end
            S_BQ_J: begin
                cw.dr_alu = 1'b1; cw.alu = ALU_ADD; cw.ld_pc = 1'b1;
            end
            S_JL_L: begin
                cw.dr_pc = 1'b1; cw.wr_reg = 1'b1; cw.rsel = SEL_RY; cw.nxt = S_JL_J;
            end
            S_JL_J: begin
                cw.dr_reg = 1'b1; cw.rsel = SEL_RX; cw.ld_pc = 1'b1;
            end
            S_HALT: begin
                cw.nxt = S_HALT;
            end
            S_EI: begin
                cw.ld_ie = 1'b1; ie_val = 1'b1;
            end
            S_DI: begin
                cw.ld_ie = 1'b1; ie_val = 1'b0;
            end
            S_RETI: begin
                cw.dr_reg = 1'b1; cw.rsel = SEL_K0; cw.ld_pc = 1'b1;
                cw.ld_ie  = 1'b1; ie_val  = 1'b1;
            end
            S_IN_SV: begin
                cw.dr_pc = 1'b1; cw.wr_reg = 1'b1; cw.rsel = SEL_K0;
                cw.ld_ie = 1'b1; ie_val    = 1'b0; cw.nxt = S_IN_AK;
            end
            S_IN_AK: begin
                cw.int_ack = 1'b1; cw.ld_mar = 1'b1; cw.nxt = S_IN_VC;
            end
            S_IN_VC: begin
                cw.dr_mem = 1'b1; cw.ld_pc = 1'b1;
            end
            default: begin
                cw.nxt = S_F0;
            end
        endcase
    end

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  st_t  st,
    input  st_t  nxt_field,
    input  logic op_test,
    input  logic chk_z,
    input  op_t  opcode,
    input  logic zero,
    input  logic int_cond,
    output st_t  nxt
);

    always_comb begin
        if (op_test)
            nxt = dispatch_tab(opcode);
        else if (chk_z)
            nxt = zero_tab({1'b0, zero});
        else if (st == INT_CHECK_ST)
            nxt = int_tab({1'b0, int_cond});
        else
            nxt = nxt_field;
    end

endmodule

// File: rtl/useq_regsel.sv
module useq_regsel
    import useq_pkg::*;
(
    input  logic [RIDX_W-1:0] rx,
    input  logic [RIDX_W-1:0] ry,
    input  logic [RIDX_W-1:0] rz,
    input  rsel_e             sel,
    output logic [RIDX_W-1:0] idx
);

    always_comb begin
        case (sel)
            SEL_RX:  idx = rx;
            SEL_RY:  idx = ry;
            SEL_RZ:  idx = rz;
            default: idx = RIDX_W'(K0_IDX);
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir_i,
    input  logic              zero_i,
    input  logic              irq_i,
    output logic [CW_W-1:0]   ctrl_o,
    output logic [RIDX_W-1:0] reg_idx_o,
    output logic              ie_o,
    output logic [ST_W-1:0]   state_o
);

    st_t   state_q;
    st_t   state_d;
    logic  ie_q;
    logic  ie_val;
    ctrl_t cw;
    logic  unused_ir_mid;

    assign unused_ir_mid = ^ir_i[RY_LSB-1:RZ_LSB+RIDX_W];

    useq_store u_store (
        .st     (state_q),
        .cw     (cw),
        .ie_val (ie_val)
    );

    useq_next u_next (
        .st        (state_q),
        .nxt_field (cw.nxt),
        .op_test   (cw.op_test),
        .chk_z     (cw.chk_z),
        .opcode    (ir_i[OP_LSB +: OP_W]),
        .zero      (zero_i),
        .int_cond  (ie_q & irq_i),
        .nxt       (state_d)
    );

    useq_regsel u_regsel (
        .rx  (ir_i[RX_LSB +: RIDX_W]),
        .ry  (ir_i[RY_LSB +: RIDX_W]),
        .rz  (ir_i[RZ_LSB +: RIDX_W]),
        .sel (cw.rsel),
        .idx (reg_idx_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_F0;
            ie_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cw.ld_ie)
                ie_q <= ie_val;
        end
    end

    assign ctrl_o  = cw;
    assign ie_o    = ie_q;
    assign state_o = state_q;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq_i,
    input logic              ie_o,
    input logic [ST_W-1:0]   state_o,
    input logic [CW_W-1:0]   ctrl_o,
    input logic [RIDX_W-1:0] reg_idx_o
);

    ctrl_t      c;
    logic [5:0] drv;

    assign c   = ctrl_t'(ctrl_o);
    assign drv = {c.dr_ie, c.dr_off, c.dr_pc, c.dr_alu, c.dr_mem, c.dr_reg};

    AST_RESET_TO_FETCH: assert property (@(posedge clk)
        rst |=> (state_o == S_F0 && !ie_o)); // R1

    AST_K0_SELECT: assert property (@(posedge clk) disable iff (rst)
        (c.rsel == SEL_K0) |-> (reg_idx_o == RIDX_W'(K0_IDX))); // R4

    AST_INT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_F0 && ie_o && irq_i) |=> (state_o == S_IN_SV)); // R5

    AST_ACK_AFTER_DISABLE: assert property (@(posedge clk) disable iff (rst)
        c.int_ack |-> !ie_o); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_F0 && !ie_o) |=> (state_o == S_F1)); // R6

    AST_EI_SETS: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_EI) |=> ie_o); // R7

    AST_DI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_DI) |=> !ie_o); // R7

    AST_RETI_SETS: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_RETI) |=> (ie_o && state_o == S_F0)); // R8

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_HALT) |=> (state_o == S_HALT)); // R11

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $countones(drv) <= 1); // R12

    AST_ACK_NO_DRIVER: assert property (@(posedge clk) disable iff (rst)
        c.int_ack |-> (drv == '0)); // R12

endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_i     (irq_i),
    .ie_o      (ie_o),
    .state_o   (state_o),
    .ctrl_o    (ctrl_o),
    .reg_idx_o (reg_idx_o)
);

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;

    localparam logic [27:0] D_REG = 28'd1 << 6;
    localparam logic [27:0] D_MEM = 28'd1 << 7;
    localparam logic [27:0] D_ALU = 28'd1 << 8;
    localparam logic [27:0] D_PC  = 28'd1 << 9;
    localparam logic [27:0] D_OFF = 28'd1 << 10;
    localparam logic [27:0] L_PC  = 28'd1 << 11;
    localparam logic [27:0] L_IR  = 28'd1 << 12;
    localparam logic [27:0] L_MAR = 28'd1 << 13;
    localparam logic [27:0] L_A   = 28'd1 << 14;
    localparam logic [27:0] L_B   = 28'd1 << 15;
    localparam logic [27:0] L_Z   = 28'd1 << 16;
    localparam logic [27:0] W_REG = 28'd1 << 17;
    localparam logic [27:0] W_MEM = 28'd1 << 18;
    localparam logic [27:0] M_SEL = 28'd3 << 19;
    localparam logic [27:0] M_ALU = 28'd3 << 21;
    localparam logic [27:0] OPT   = 28'd1 << 23;
    localparam logic [27:0] CHKZ  = 28'd1 << 24;
    localparam logic [27:0] L_IE  = 28'd1 << 25;
    localparam logic [27:0] D_IE  = 28'd1 << 26;
    localparam logic [27:0] ACK   = 28'd1 << 27;
    localparam logic [27:0] DRV   = D_REG | D_MEM | D_ALU | D_PC | D_OFF | D_IE;

    function automatic logic [27:0] sel(input int k);
        return 28'(k) << 19;
    endfunction
    function automatic logic [27:0] alu(input int k);
        return 28'(k) << 21;
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ir_i = '0;
    logic        zero_i = 1'b0;
    logic        irq_i = 1'b0;
    logic [27:0] ctrl_o;
    logic [3:0]  reg_idx_o;
    logic        ie_o;
    logic [5:0]  state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic exp_ie = 1'b0;

    typedef struct {
        logic [5:0]  st;
        logic        ie;
        logic [27:0] msk;
        logic [27:0] val;
        int          ridx;
        string       tag;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;

    useq_ctrl u_useq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ir_i      (ir_i),
        .zero_i    (zero_i),
        .irq_i     (irq_i),
        .ctrl_o    (ctrl_o),
        .reg_idx_o (reg_idx_o),
        .ie_o      (ie_o),
        .state_o   (state_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [5:0] st, input logic ie, input logic [27:0] msk,
                        input logic [27:0] val, input int ridx, input string tag);
        item_t it;
        it.st = st; it.ie = ie; it.msk = msk; it.val = val; it.ridx = ridx; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: one expected item per cycle, sampled at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk(state_o === it.st, it.tag, "state", 32'(state_o), 32'(it.st));
            chk(ie_o === it.ie, it.tag, "ie", 32'(ie_o), 32'(it.ie));
            chk((ctrl_o & it.msk) === it.val, it.tag, "ctrl", 32'(ctrl_o & it.msk), 32'(it.val));
            if (it.ridx >= 0)
                chk(reg_idx_o === 4'(it.ridx), it.tag, "reg_idx", 32'(reg_idx_o), 32'(it.ridx));
            chk($countones(ctrl_o & DRV) <= 1 && !(ctrl_o[27] && (ctrl_o & DRV) != 0),
                "R12", "drivers", 32'(ctrl_o & DRV), 32'h0);
        end
    end

    task automatic go(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic fetch_items(input logic ie, input string tag);
        push(6'd0, ie, D_PC | L_MAR | L_A, D_PC | L_MAR | L_A, -1, tag);
        push(6'd1, ie, D_MEM | L_IR, D_MEM | L_IR, -1, tag);
        push(6'd2, ie, D_ALU | L_PC | M_ALU | OPT, D_ALU | L_PC | alu(3) | OPT, -1, tag);
    endtask

    task automatic setin(input logic [31:0] ir, input logic irq, input logic z);
        ir_i = ir; irq_i = irq; zero_i = z;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // reset state, full control word of state 0 (R1, R2)
        go(3);
        chk(state_o === 6'd0, "R1", "reset state", 32'(state_o), 0);
        chk(ie_o === 1'b0, "R1", "reset ie", 32'(ie_o), 0);
        chk(ctrl_o === 28'h0006201, "R2", "state0 word", 32'(ctrl_o), 32'h6201);
        rst = 1'b0;

        // R13 add: RX=3 RY=5 RZ=7 ; R3 fetch ; R4 selects
        setin({4'h0, 4'd3, 4'd5, 16'h0, 4'd7}, 1'b0, 1'b0);
        fetch_items(exp_ie, "R3");
        push(6'd4, exp_ie, D_REG | L_A | M_SEL, D_REG | L_A | sel(1), 5, "R13");
        push(6'd5, exp_ie, D_REG | L_B | M_SEL, D_REG | L_B | sel(2), 7, "R4");
        push(6'd6, exp_ie, D_ALU | W_REG | M_SEL | M_ALU, D_ALU | W_REG | sel(0) | alu(0), 3, "R13");
        go(6);

        // R13 nand: RX=9 RY=1 RZ=14
        setin({4'h1, 4'd9, 4'd1, 16'h0, 4'd14}, 1'b0, 1'b0);
        fetch_items(exp_ie, "R3");
        push(6'd7, exp_ie, D_REG | L_A | M_SEL, D_REG | L_A | sel(1), 1, "R13");
        push(6'd8, exp_ie, D_REG | L_B | M_SEL, D_REG | L_B | sel(2), 14, "R13");
        push(6'd9, exp_ie, D_ALU | W_REG | M_SEL | M_ALU, D_ALU | W_REG | sel(0) | alu(1), 9, "R13");
        go(6);

        // R6 masked request, R10 unassigned opcode 1000
        setin({4'h8, 28'h0}, 1'b1, 1'b0);
        fetch_items(exp_ie, "R6");
        go(3);

        // R7 enable
        setin({4'hA, 28'h0}, 1'b0, 1'b0);
        fetch_items(exp_ie, "R7");
        push(6'd30, exp_ie, L_IE | DRV, L_IE, -1, "R7");
        go(4);
        exp_ie = 1'b1;

        // R5 interrupt entry
        setin({4'h0, 28'h0}, 1'b1, 1'b0);
        push(6'd0, 1'b1, D_PC | L_MAR | L_A, D_PC | L_MAR | L_A, -1, "R5");
        push(6'd33, 1'b1, D_PC | W_REG | L_IE | M_SEL, D_PC | W_REG | L_IE | sel(3), 12, "R5");
        push(6'd34, 1'b0, ACK | L_MAR | DRV, ACK | L_MAR, -1, "R5");
        push(6'd35, 1'b0, D_MEM | L_PC, D_MEM | L_PC, -1, "R5");
        go(4);
        exp_ie = 1'b0;

        // R8 return
        setin({4'hC, 28'h0}, 1'b0, 1'b0);
        fetch_items(exp_ie, "R8");
        push(6'd32, 1'b0, D_REG | L_PC | L_IE | M_SEL, D_REG | L_PC | L_IE | sel(3), 12, "R8");
        go(4);
        exp_ie = 1'b1;

        // R7 disable
        setin({4'hB, 28'h0}, 1'b0, 1'b0);
        fetch_items(exp_ie, "R7");
        push(6'd31, exp_ie, L_IE | DRV, L_IE, -1, "R7");
        go(4);
        exp_ie = 1'b0;

        // R6 request after disable, R10 opcode 1111
        setin({4'hF, 28'h0}, 1'b1, 1'b0);
        fetch_items(exp_ie, "R6");
        go(3);

        // R9 branch taken: RX=2 RY=4
        setin({4'h5, 4'd2, 4'd4, 20'h0}, 1'b0, 1'b1);
        fetch_items(exp_ie, "R9");
        push(6'd21, exp_ie, D_REG | L_A | M_SEL, D_REG | L_A | sel(0), 2, "R9");
        push(6'd22, exp_ie, D_REG | L_B | M_SEL, D_REG | L_B | sel(1), 4, "R9");
        push(6'd23, exp_ie, D_ALU | L_Z | M_ALU, D_ALU | L_Z | alu(2), -1, "R9");
        push(6'd24, exp_ie, D_PC | L_A | CHKZ, D_PC | L_A | CHKZ, -1, "R9");
        push(6'd25, exp_ie, D_OFF | L_B, D_OFF | L_B, -1, "R9");
        push(6'd26, exp_ie, D_ALU | L_PC | M_ALU, D_ALU | L_PC | alu(0), -1, "R9");
        go(9);

        // R9 branch not taken
        setin({4'h5, 4'd2, 4'd4, 20'h0}, 1'b0, 1'b0);
        fetch_items(exp_ie, "R9");
        push(6'd21, exp_ie, D_REG | L_A, D_REG | L_A, 2, "R9");
        push(6'd22, exp_ie, D_REG | L_B, D_REG | L_B, 4, "R9");
        push(6'd23, exp_ie, D_ALU | L_Z, D_ALU | L_Z, -1, "R9");
        push(6'd24, exp_ie, CHKZ, CHKZ, -1, "R9");
        go(7);
        chk(state_o === 6'd0, "R9", "not-taken return", 32'(state_o), 0);

        // R11 halt
        setin({4'h7, 28'h0}, 1'b0, 1'b0);
        fetch_items(exp_ie, "R11");
        push(6'd29, exp_ie, DRV, 28'h0, -1, "R11");
        push(6'd29, exp_ie, DRV, 28'h0, -1, "R11");
        push(6'd29, exp_ie, DRV, 28'h0, -1, "R11");
        go(6);
        chk(state_o === 6'd29, "R11", "halt hold", 32'(state_o), 29);
        rst = 1'b1;
        go(1);
        chk(state_o === 6'd0, "R1", "reset from halt", 32'(state_o), 0);
        chk(ie_o === 1'b0, "R1", "reset ie", 32'(ie_o), 0);
        rst = 1'b0;
        go(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule